// File: doc/BRIEF.md
# Per-Pin Programmable Interrupt Detector

This block watches a vector of sampled pin levels and turns level conditions or transitions on individual pins into sticky interrupt status bits. Each update presents a level vector together with a validity mask. Only the masked bits replace the remembered input, so a partial read of one bank of pins updates only that bank. The merged result is then compared with the previous remembered value to find which pins changed.

Each pin has its own mode: level-high, level-low, rising edge, falling edge or both edges. The mode is set by a command that names a pin and a mode code. A host reads the status vector and clears it in a single request. An event that arrives in the same cycle as the clear is kept.

Top module: `pin_irq_detect`

## Requirements
- R1: After reset the status vector is zero, the remembered input is zero and every pin is in both-edges mode. A first update that drives a pin high therefore flags that pin.
- R2: An update forms the new remembered input as the old value where the mask bit is 0 and the sampled level where the mask bit is 1. Unmasked bits neither change nor produce an edge.
- R3: A pin in an edge mode sets its status bit only on an update in which its remembered level changed. It needs a new level of 1 with rising enabled, or a new level of 0 with falling enabled. Both-edges mode enables both.
- R4: A pin in a level mode sets its status bit on every update, masked or not, in which its merged level matches its enabled level.
- R5: Mode codes on `cfg_mode` are 1 level-high, 2 level-low, 3 rising, 4 falling and 5 both-edges. They take effect from the cycle after the command.
- R6: Code 0 (disable) leaves the pin's mode unchanged. Codes 6 and 7 also leave it unchanged and raise `cfg_err` for exactly the following cycle.
- R7: Status bits are sticky. They stay set until a clear, and they change only on an update or a clear.
- R8: While `clr_req` is high, `irq_status` shows the vector being taken. After that edge the status holds only the events detected in that same cycle.
- R9: Pins at index `PIN_CNT` and above never raise status, whatever their mode or level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Mode command strobe |
| cfg_pin | input | IDX_W | Pin addressed by the command |
| cfg_mode | input | 3 | Mode code (see R5, R6) |
| cfg_err | output | 1 | One-cycle flag for a rejected mode code |
| samp_valid | input | 1 | Update strobe |
| samp_level | input | PIN_W | Sampled pin levels |
| samp_mask | input | PIN_W | 1 marks a sampled bit as valid |
| clr_req | input | 1 | Sample-and-clear request |
| irq_status | output | PIN_W | Sticky status vector |

## Verification
A wrong remembered input does not show up at the time it goes wrong. It surfaces on a later update, as a missing or spurious edge on the pins whose stored level is wrong. For that reason the directed sequences chain updates, so each one inherits the state the previous one left behind.

A wrong mode mask shows only on the first update after the command that should have set it. The tests therefore follow every configuration change with an update that separates the candidate modes.

Status corruption appears one edge after the offending update or clear. The clear collision is checked both in the cycle it occurs and in the cycle after.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
   typedef enum logic [2:0] {
      MODE_OFF  = 3'd0,
      MODE_HIGH = 3'd1,
      MODE_LOW  = 3'd2,
      MODE_RISE = 3'd3,
      MODE_FALL = 3'd4,
      MODE_BOTH = 3'd5
   } pin_mode_e;
endpackage

// File: rtl/pin_irq_mode_regs.sv
module pin_irq_mode_regs #(
   parameter int PIN_W = 32,
   localparam int IDX_W = (PIN_W > 1) ? $clog2(PIN_W) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_valid,
   input  logic [IDX_W-1:0] cfg_pin,
   input  logic [2:0]       cfg_mode,
   output logic [PIN_W-1:0] edge_sel,
   output logic [PIN_W-1:0] pol_hi,
   output logic [PIN_W-1:0] pol_lo,
   output logic             cfg_err
);
   import pin_irq_pkg::*;

   logic [PIN_W-1:0] edge_d, hi_d, lo_d, bit_sel;
   logic             err_d;

   always_comb begin
      bit_sel = '0;
      bit_sel[cfg_pin] = 1'b1;
      edge_d = edge_sel;
      hi_d   = pol_hi;
      lo_d   = pol_lo;
      err_d  = 1'b0;
      if (cfg_valid) begin
         case (cfg_mode)
            MODE_OFF:  ;
            MODE_HIGH: begin edge_d &= ~bit_sel; hi_d |=  bit_sel; lo_d &= ~bit_sel; end
            MODE_LOW:  begin edge_d &= ~bit_sel; hi_d &= ~bit_sel; lo_d |=  bit_sel; end
            MODE_RISE: begin edge_d |=  bit_sel; hi_d |=  bit_sel; lo_d &= ~bit_sel; end
            MODE_FALL: begin edge_d |=  bit_sel; hi_d &= ~bit_sel; lo_d |=  bit_sel; end
            MODE_BOTH: begin edge_d |=  bit_sel; hi_d |=  bit_sel; lo_d |=  bit_sel; end
            default:   err_d = 1'b1;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         edge_sel <= '1;
         pol_hi   <= '1;
         pol_lo   <= '1;
         cfg_err  <= 1'b0;
      end else begin
         edge_sel <= edge_d;
         pol_hi   <= hi_d;
         pol_lo   <= lo_d;
         cfg_err  <= err_d;
      end
   end
endmodule

// File: rtl/pin_irq_merge.sv
module pin_irq_merge #(
   parameter int PIN_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             samp_valid,
   input  logic [PIN_W-1:0] samp_level,
   input  logic [PIN_W-1:0] samp_mask,
   output logic [PIN_W-1:0] merged,
   output logic [PIN_W-1:0] changed
);
   logic [PIN_W-1:0] held_q;

   assign merged  = (held_q & ~samp_mask) | (samp_level & samp_mask);
   assign changed = held_q ^ merged;

   always_ff @(posedge clk) begin
      if (!rst_n)          held_q <= '0;
      else if (samp_valid) held_q <= merged;
   end
endmodule

// File: rtl/pin_irq_eval.sv
module pin_irq_eval #(
   parameter int PIN_W   = 32,
   parameter int PIN_CNT = 32
) (
   input  logic             samp_valid,
   input  logic [PIN_W-1:0] merged,
   input  logic [PIN_W-1:0] changed,
   input  logic [PIN_W-1:0] edge_sel,
   input  logic [PIN_W-1:0] pol_hi,
   input  logic [PIN_W-1:0] pol_lo,
   output logic [PIN_W-1:0] events
);
   for (genvar i = 0; i < PIN_W; i++) begin : g_pin
      if (i < PIN_CNT) begin : g_live
         logic match;
         assign match = (merged[i] & pol_hi[i]) | (~merged[i] & pol_lo[i]);
         assign events[i] = samp_valid & match & (~edge_sel[i] | changed[i]);
      end else begin : g_dead
         assign events[i] = 1'b0;
      end
   end
endmodule

// File: rtl/pin_irq_detect.sv
module pin_irq_detect #(
   parameter int PIN_W   = 32,
   parameter int PIN_CNT = 32,
   localparam int IDX_W  = (PIN_W > 1) ? $clog2(PIN_W) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_valid,
   input  logic [IDX_W-1:0] cfg_pin,
   input  logic [2:0]       cfg_mode,
   output logic             cfg_err,
   input  logic             samp_valid,
   input  logic [PIN_W-1:0] samp_level,
   input  logic [PIN_W-1:0] samp_mask,
   input  logic             clr_req,
   output logic [PIN_W-1:0] irq_status
);
   if (PIN_CNT < 1 || PIN_CNT > PIN_W) begin : g_bad_cnt
      $error("pin_irq_detect: PIN_CNT must lie in 1..PIN_W");
   end
   if (PIN_W > 64) begin : g_bad_w
      $error("pin_irq_detect: PIN_W above 64 is not supported");
   end

   logic [PIN_W-1:0] edge_sel, pol_hi, pol_lo, merged, changed, events;

   pin_irq_mode_regs #(.PIN_W(PIN_W)) u_mode (
      .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_pin(cfg_pin),
      .cfg_mode(cfg_mode), .edge_sel(edge_sel), .pol_hi(pol_hi),
      .pol_lo(pol_lo), .cfg_err(cfg_err)
   );

   pin_irq_merge #(.PIN_W(PIN_W)) u_merge (
      .clk(clk), .rst_n(rst_n), .samp_valid(samp_valid),
      .samp_level(samp_level), .samp_mask(samp_mask),
      .merged(merged), .changed(changed)
   );

   pin_irq_eval #(.PIN_W(PIN_W), .PIN_CNT(PIN_CNT)) u_eval (
      .samp_valid(samp_valid), .merged(merged), .changed(changed),
      .edge_sel(edge_sel), .pol_hi(pol_hi), .pol_lo(pol_lo), .events(events)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) irq_status <= '0;
      else        irq_status <= (clr_req ? '0 : irq_status) | events;
   end
endmodule

// File: rtl/pin_irq_detect_chk.sv
module pin_irq_detect_chk #(
   parameter int PIN_W   = 32,
   parameter int PIN_CNT = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_valid,
   input logic [2:0]       cfg_mode,
   input logic             cfg_err,
   input logic             samp_valid,
   input logic             clr_req,
   input logic [PIN_W-1:0] irq_status
);
   localparam logic [PIN_W-1:0] LIVE = (PIN_CNT >= PIN_W) ? '1 : ((PIN_W)'(1) << PIN_CNT) - 1'b1;

   // R9
   dead_pins_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_status & ~LIVE) == '0);

   // R7
   sticky_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_req |=> ((irq_status & $past(irq_status)) == $past(irq_status)));

   // R7
   idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!samp_valid && !clr_req) |=> $stable(irq_status));

   // R8
   clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req && !samp_valid) |=> (irq_status == '0));

   // R6
   bad_code_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_valid && cfg_mode > 3'd5) |=> cfg_err);

   // R6
   err_only_on_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_valid |=> !cfg_err);
endmodule

bind pin_irq_detect pin_irq_detect_chk #(.PIN_W(PIN_W), .PIN_CNT(PIN_CNT)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_mode(cfg_mode),
   .cfg_err(cfg_err), .samp_valid(samp_valid), .clr_req(clr_req),
   .irq_status(irq_status)
);

// File: tb/pin_irq_detect_bench.sv
module pin_irq_detect_bench;
   localparam int CLK_PERIOD = 10;
   localparam int W = 32;
   localparam int CNT = 24;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_valid = 1'b0;
   logic [4:0]    cfg_pin = '0;
   logic [2:0]    cfg_mode = '0;
   logic          cfg_err;
   logic          samp_valid = 1'b0;
   logic [W-1:0]  samp_level = '0;
   logic [W-1:0]  samp_mask = '0;
   logic          clr_req = 1'b0;
   logic [W-1:0]  irq_status;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pin_irq_detect #(.PIN_W(W), .PIN_CNT(CNT)) u_pin_irq_detect (
      .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_pin(cfg_pin),
      .cfg_mode(cfg_mode), .cfg_err(cfg_err), .samp_valid(samp_valid),
      .samp_level(samp_level), .samp_mask(samp_mask), .clr_req(clr_req),
      .irq_status(irq_status)
   );

   task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic do_cfg(input int pin, input logic [2:0] mode);
      @(negedge clk);
      cfg_valid = 1'b1; cfg_pin = 5'(pin); cfg_mode = mode;
      @(negedge clk);
      cfg_valid = 1'b0;
   endtask

   task automatic do_samp(input logic [W-1:0] lvl, input logic [W-1:0] msk);
      @(negedge clk);
      samp_valid = 1'b1; samp_level = lvl; samp_mask = msk;
      @(negedge clk);
      samp_valid = 1'b0;
   endtask

   task automatic do_clear();
      @(negedge clk);
      clr_req = 1'b1;
      @(negedge clk);
      clr_req = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 reset status", irq_status, '0);
      check("R1 reset err", {31'b0, cfg_err}, '0);
      do_samp(32'h0000_00FF, '1);
      check("R1 default both-edges", irq_status, 32'h0000_00FF);
      do_clear();
      check("R8 clear", irq_status, '0);
   endtask

   task automatic t_merge();
      do_samp(32'hFFFF_FFFF, 32'h0000_FF00);
      check("R2 masked merge", irq_status, 32'h0000_FF00);
      do_clear();
      do_samp(32'h0000_0000, 32'h0000_0000);
      check("R2 empty mask no edge", irq_status, '0);
   endtask

   task automatic t_edges();
      do_cfg(0, 3'd3);
      do_cfg(1, 3'd4);
      do_samp(32'h0000_0000, '1);
      check("R3 falling, pin0 rise-only", irq_status, 32'h0000_FFFE);
      do_clear();
      do_samp(32'h0000_0003, '1);
      check("R3 rising, pin1 fall-only", irq_status, 32'h0000_0001);
      do_clear();
      do_samp(32'h0000_0003, '1);
      check("R3 no change no edge", irq_status, '0);
   endtask

   task automatic t_levels();
      do_cfg(4, 3'd1);
      do_cfg(5, 3'd2);
      do_samp(32'h0000_0003, '0);
      check("R4 low level on masked-out update", irq_status, 32'h0000_0020);
      do_clear();
      do_samp(32'h0000_0003, '0);
      check("R4 level repeats every update", irq_status, 32'h0000_0020);
      do_clear();
      do_samp(32'h0000_0013, '1);
      check("R5 high and low codes", irq_status, 32'h0000_0030);
      do_clear();
   endtask

   task automatic t_cfg_codes();
      do_cfg(4, 3'd0);
      check("R6 disable no err", {31'b0, cfg_err}, '0);
      do_cfg(5, 3'd7);
      check("R6 bad code flags err", {31'b0, cfg_err}, 32'h1);
      @(negedge clk);
      check("R6 err lasts one cycle", {31'b0, cfg_err}, '0);
      do_samp(32'h0000_0013, '0);
      check("R6 modes kept after disable and bad code", irq_status, 32'h0000_0030);
   endtask

   task automatic t_collision();
      @(negedge clk);
      check("R7 sticky while idle", irq_status, 32'h0000_0030);
      samp_valid = 1'b1; samp_level = 32'h0000_0013; samp_mask = '0; clr_req = 1'b1;
      check("R8 clear returns vector", irq_status, 32'h0000_0030);
      @(negedge clk);
      samp_valid = 1'b0; clr_req = 1'b0;
      check("R8 same-cycle event survives", irq_status, 32'h0000_0030);
      do_clear();
      check("R8 clear alone", irq_status, '0);
   endtask

   task automatic t_dead_pins();
      do_cfg(30, 3'd1);
      do_samp(32'hFF00_0013, '1);
      check("R9 high pins ignored", irq_status & 32'hFF00_0000, '0);
      do_samp(32'h0000_0013, '1);
      check("R9 high pins ignored on fall", irq_status & 32'hFF00_0000, '0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_merge();
      t_edges();
      t_levels();
      t_cfg_codes();
      t_collision();
      t_dead_pins();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule